// File: doc/BRIEF.md
# Interrupt Source Mask and Route Register Bank

This block gathers a bank of level-sensitive interrupt request lines, merges each with a software-raised request bit, and steers every source to one of two destinations. The first is a normal, maskable request class. The second is a fast request class that is never masked. Software reaches the bank through a plain word-addressed register port with separate read and write strobes. Enable bits and software request bits each have a set address and a clear address. Writing a 1 to one of these addresses affects only the bit in that position, so one driver can change its own bit without a read-modify-write race with another driver.

Three status views can be read back: the merged raw requests, the requests that survive masking on the normal path, and the requests routed to the fast path. The masked normal-path vector is also driven as a port so that a downstream priority resolver can consume it directly. A single summary output signals any pending fast-path request. A read-only block of identification words sits at the top of the address window.

Top module: `intr_steer_regs`

## Requirements
- R1: The raw request word is the bitwise OR of `req_i` and the software request bits. A read of word address 2 returns it.
- R2: The normal-path status is raw AND enable AND NOT route. It is driven on `irq_pend_o` in the same cycle and is returned by a read of word address 0.
- R3: The fast-path status is raw AND route. A read of word address 1 returns it. `fiq_o` is 1 exactly when any bit of it is 1, whatever the enable bits hold.
- R4: A write to word address 4 sets each enable bit whose data bit is 1. A write to word address 5 clears each enable bit whose data bit is 1. Other enable bits keep their value. A read of word address 4 returns the enable bits.
- R5: A write to word address 6 sets each software request bit whose data bit is 1. A write to word address 7 clears each software request bit whose data bit is 1. A read of word address 6 returns the software request bits.
- R6: A write to word address 3 replaces all route bits with the data word. A read of word address 3 returns the route bits. A route bit of 1 selects the fast path.
- R7: A write to word address 0 changes no state.
- R8: A write to word address 8 stores data bit 0 as the lock bit. A read of word address 8 returns the lock bit in bit 0 and zeros in bits 31..1. The lock bit has no effect on any output.
- R9: Reads of word addresses 0x3F8 through 0x3FF return, in address order, 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, zero-extended to 32 bits.
- R10: After reset, the enable, route, software request and lock bits, and `rdata_o`, are all zero.
- R11: Reads of any other word address, including the write-only addresses 5 and 7, return zero. Writes to any other word address change no state.
- R12: `rdata_o` is loaded at the rising edge where `rd_en_i` is 1 and holds its value otherwise. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Level-sensitive hardware request lines |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 10 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_pend_o | output | 32 | Masked normal-path request vector |
| fiq_o | output | 1 | Any fast-path request pending |

## Verification
Corruption in the enable, route or software request bits shows on `irq_pend_o` or `fiq_o` in the first cycle after the edge that stored it, as long as any source line touches the affected bit. The bench therefore compares both outputs with a model on every clock, while it drives varied request patterns. A fault that only the lock bit or a mis-decoded read address can reveal shows up one edge after a read strobe, on `rdata_o`. Because of this, the sequences repeatedly sweep every defined address and several undefined ones.

// File: rtl/intr_steer_pkg.sv
package intr_steer_pkg;

    // Decoded register kinds seen by the register port
    typedef enum logic [3:0] {
        RK_IRQ_STAT,
        RK_FIQ_STAT,
        RK_RAW_STAT,
        RK_ROUTE,
        RK_EN_SET,
        RK_EN_CLR,
        RK_SW_SET,
        RK_SW_CLR,
        RK_LOCK,
        RK_IDENT,
        RK_NONE
    } reg_kind_e;

    // Word addresses whose meaning software depends on
    localparam int unsigned OFS_IRQ_STAT = 0;
    localparam int unsigned OFS_FIQ_STAT = 1;
    localparam int unsigned OFS_RAW_STAT = 2;
    localparam int unsigned OFS_ROUTE    = 3;
    localparam int unsigned OFS_EN_SET   = 4;
    localparam int unsigned OFS_EN_CLR   = 5;
    localparam int unsigned OFS_SW_SET   = 6;
    localparam int unsigned OFS_SW_CLR   = 7;
    localparam int unsigned OFS_LOCK     = 8;
    localparam int unsigned IDENT_WORDS  = 8;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h90;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/isr_addr_decode.sv
module isr_addr_decode
    import intr_steer_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [2:0]        ident_idx_o
);
    localparam int unsigned WIN_WORDS  = 1 << ADDR_W;
    localparam int unsigned IDENT_BASE = WIN_WORDS - IDENT_WORDS;

    always_comb begin
        ident_idx_o = addr_i[2:0];
        if (32'(addr_i) >= IDENT_BASE) begin
            kind_o = RK_IDENT;
        end else if (addr_i == ADDR_W'(OFS_IRQ_STAT)) begin
            kind_o = RK_IRQ_STAT;
        end else if (addr_i == ADDR_W'(OFS_FIQ_STAT)) begin
            kind_o = RK_FIQ_STAT;
        end else if (addr_i == ADDR_W'(OFS_RAW_STAT)) begin
            kind_o = RK_RAW_STAT;
        end else if (addr_i == ADDR_W'(OFS_ROUTE)) begin
            kind_o = RK_ROUTE;
        end else if (addr_i == ADDR_W'(OFS_EN_SET)) begin
            kind_o = RK_EN_SET;
        end else if (addr_i == ADDR_W'(OFS_EN_CLR)) begin
            kind_o = RK_EN_CLR;
        end else if (addr_i == ADDR_W'(OFS_SW_SET)) begin
            kind_o = RK_SW_SET;
        end else if (addr_i == ADDR_W'(OFS_SW_CLR)) begin
            kind_o = RK_SW_CLR;
        end else if (addr_i == ADDR_W'(OFS_LOCK)) begin
            kind_o = RK_LOCK;
        end else begin
            kind_o = RK_NONE;
        end
    end
endmodule

// File: rtl/isr_ctrl_regs.sv
module isr_ctrl_regs
    import intr_steer_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  reg_kind_e          kind_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] route_o,
    output logic [NUM_SRC-1:0] soft_o,
    output logic               lock_o
);
    // One-hot style strobes for each write action
    logic wr_en_set, wr_en_clr, wr_sw_set, wr_sw_clr, wr_route, wr_lock;

    always_comb begin
        wr_en_set = 1'b0;
        wr_en_clr = 1'b0;
        wr_sw_set = 1'b0;
        wr_sw_clr = 1'b0;
        wr_route  = 1'b0;
        wr_lock   = 1'b0;
        if (wr_en_i) begin
            unique case (kind_i)
                RK_EN_SET: wr_en_set = 1'b1;
                RK_EN_CLR: wr_en_clr = 1'b1;
                RK_SW_SET: wr_sw_set = 1'b1;
                RK_SW_CLR: wr_sw_clr = 1'b1;
                RK_ROUTE:  wr_route  = 1'b1;
                RK_LOCK:   wr_lock   = 1'b1;
                default: ;
            endcase
        end
    end

    // Per-source storage cells
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_o[g]    <= 1'b0;
                soft_o[g]  <= 1'b0;
                route_o[g] <= 1'b0;
            end else begin
                if (wr_en_set && wdata_i[g]) begin
                    en_o[g] <= 1'b1;
                end else if (wr_en_clr && wdata_i[g]) begin
                    en_o[g] <= 1'b0;
                end
                if (wr_sw_set && wdata_i[g]) begin
                    soft_o[g] <= 1'b1;
                end else if (wr_sw_clr && wdata_i[g]) begin
                    soft_o[g] <= 1'b0;
                end
                if (wr_route) begin
                    route_o[g] <= wdata_i[g];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_o <= 1'b0;
        end else if (wr_lock) begin
            lock_o <= wdata_i[0];
        end
    end
endmodule

// File: rtl/isr_status_path.sv
module isr_status_path #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] soft_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] route_i,
    output logic [NUM_SRC-1:0] raw_o,
    output logic [NUM_SRC-1:0] irq_o,
    output logic [NUM_SRC-1:0] fiq_o,
    output logic               fiq_any_o
);
    always_comb begin
        raw_o     = req_i | soft_i;
        irq_o     = raw_o & en_i & ~route_i;
        fiq_o     = raw_o & route_i;
        fiq_any_o = |fiq_o;
    end
endmodule

// File: rtl/intr_steer_regs.sv
module intr_steer_regs
    import intr_steer_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [NUM_SRC-1:0] irq_pend_o,
    output logic               fiq_o
);
    reg_kind_e          kind;
    logic [2:0]         ident_idx;
    logic [NUM_SRC-1:0] en_w, route_w, soft_w;
    logic               lock_w;
    logic [NUM_SRC-1:0] raw_w, irq_w, fiq_w;
    logic               fiq_any_w;
    logic [DATA_W-1:0]  rd_next;

    isr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i      (addr_i),
        .kind_o      (kind),
        .ident_idx_o (ident_idx)
    );

    isr_ctrl_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .kind_i  (kind),
        .wdata_i (wdata_i),
        .en_o    (en_w),
        .route_o (route_w),
        .soft_o  (soft_w),
        .lock_o  (lock_w)
    );

    isr_status_path #(.NUM_SRC(NUM_SRC)) u_stat (
        .req_i     (req_i),
        .soft_i    (soft_w),
        .en_i      (en_w),
        .route_i   (route_w),
        .raw_o     (raw_w),
        .irq_o     (irq_w),
        .fiq_o     (fiq_w),
        .fiq_any_o (fiq_any_w)
    );

    // Read selection
    always_comb begin
        unique case (kind)
            RK_IRQ_STAT: rd_next = DATA_W'(irq_w);
            RK_FIQ_STAT: rd_next = DATA_W'(fiq_w);
            RK_RAW_STAT: rd_next = DATA_W'(raw_w);
            RK_ROUTE:    rd_next = DATA_W'(route_w);
            RK_EN_SET:   rd_next = DATA_W'(en_w);
            RK_SW_SET:   rd_next = DATA_W'(soft_w);
            RK_LOCK:     rd_next = DATA_W'(lock_w);
            RK_IDENT:    rd_next = DATA_W'(ident_byte(ident_idx));
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_next;
        end
    end

    assign irq_pend_o = irq_w;
    assign fiq_o      = fiq_any_w;
endmodule

// File: rtl/intr_steer_regs_chk.sv
module intr_steer_regs_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [NUM_SRC-1:0] req_i,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] route_q,
    input logic [NUM_SRC-1:0] soft_q,
    input logic               lock_q,
    input logic [NUM_SRC-1:0] irq_pend_o,
    input logic               fiq_o
);
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(4)) |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]))); // R4
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(5)) |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == '0)); // R4
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(6)) |=> ((soft_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]))); // R5
    AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(7)) |=> ((soft_q & $past(wdata_i[NUM_SRC-1:0])) == '0)); // R5
    AST_ROUTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(3)) |=> (route_q == $past(wdata_i[NUM_SRC-1:0]))); // R6
    AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(8)) |=> (lock_q == $past(wdata_i[0]))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || addr_i == ADDR_W'(0)) |=> ($stable(en_q) && $stable(route_q) && $stable(soft_q) && $stable(lock_q))); // R7
    AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend_o & ~en_q) == '0) && ((irq_pend_o & route_q) == '0)); // R2
    AST_PEND_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend_o & ~(req_i | soft_q)) == '0)); // R2
    AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (route_q != '0)); // R3
    AST_FIQ_EN_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(req_i) && $stable(route_q) && $stable(soft_q)) |-> $stable(fiq_o)); // R3
endmodule

bind intr_steer_regs intr_steer_regs_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .req_i      (req_i),
    .en_q       (en_w),
    .route_q    (route_w),
    .soft_q     (soft_w),
    .lock_q     (lock_w),
    .irq_pend_o (irq_pend_o),
    .fiq_o      (fiq_o)
);

// File: tb/intr_steer_regs_tb.sv
module intr_steer_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pend;
    logic        fiq;

    int total = 0;
    int bad = 0;

    // Behavioural reference state
    logic [31:0] m_en = '0, m_route = '0, m_soft = '0, m_rd = '0;
    logic        m_lock = 1'b0;
    byte unsigned id_tab [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always #4 clk = ~clk;

    intr_steer_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_pend_o (pend),
        .fiq_o      (fiq)
    );

    function automatic logic [31:0] m_read(int a);
        logic [31:0] raw;
        raw = req | m_soft;
        case (a)
            0: return raw & m_en & ~m_route;
            1: return raw & m_route;
            2: return raw;
            3: return m_route;
            4: return m_en;
            6: return m_soft;
            8: return {31'b0, m_lock};
            default: begin
                if (a >= 1016 && a <= 1023) return {24'b0, id_tab[a-1016]};
                return 32'h0;
            end
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        logic [31:0] raw;
        raw = req | m_soft;
        chk(tag, "rdata", rdata, m_rd);
        chk(tag, "irq_pend", pend, raw & m_en & ~m_route);
        chk(tag, "fiq", {31'b0, fiq}, {31'b0, |(raw & m_route)});
    endtask

    task automatic step(string tag, bit w, bit r, int a, logic [31:0] d, logic [31:0] rq);
        wr_en = w; rd_en = r; addr = a[9:0]; wdata = d; req = rq;
        @(posedge clk);
        if (r) m_rd = m_read(a);
        if (w) begin
            case (a)
                3: m_route = d;
                4: m_en = m_en | d;
                5: m_en = m_en & ~d;
                6: m_soft = m_soft | d;
                7: m_soft = m_soft & ~d;
                8: m_lock = d[0];
                default: ;
            endcase
        end
        #2;
        compare_all(tag);
    endtask

    task automatic sweep(string tag, logic [31:0] rq);
        for (int a = 0; a <= 9; a++) step(tag, 1'b0, 1'b1, a, 32'h0, rq);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare_all("R10");
        rst_n = 1'b1;
        sweep("R10", 32'h0);

        // R1 raw merge of hardware and software
        step("R1", 1'b0, 1'b1, 2, 32'h0, 32'hA5A5_0F0F);
        step("R5", 1'b1, 1'b0, 6, 32'h0000_F0F0, 32'hA5A5_0F0F);
        step("R1", 1'b0, 1'b1, 2, 32'h0, 32'hA5A5_0F0F);
        step("R5", 1'b0, 1'b1, 6, 32'h0, 32'h0);
        step("R5", 1'b1, 1'b0, 7, 32'h0000_3030, 32'h0);
        step("R5", 1'b0, 1'b1, 6, 32'h0, 32'h1);

        // R4 enable set/clear with partial masks
        step("R4", 1'b1, 1'b0, 4, 32'hFF00_FF00, 32'hFFFF_FFFF);
        step("R4", 1'b1, 1'b0, 4, 32'h0000_000F, 32'hFFFF_FFFF);
        step("R4", 1'b1, 1'b0, 5, 32'h0F00_0003, 32'hFFFF_FFFF);
        step("R4", 1'b0, 1'b1, 4, 32'h0, 32'h1234_5678);
        step("R2", 1'b0, 1'b1, 0, 32'h0, 32'h1234_5678);

        // R6 routing and R3 fast path independent of enable
        step("R6", 1'b1, 1'b0, 3, 32'h8000_0001, 32'h0);
        step("R3", 1'b0, 1'b1, 1, 32'h0, 32'h8000_0000);
        step("R3", 1'b1, 1'b0, 5, 32'hFFFF_FFFF, 32'h8000_0000);
        step("R3", 1'b0, 1'b1, 1, 32'h0, 32'h8000_0000);
        step("R3", 1'b0, 1'b0, 0, 32'h0, 32'h0000_0001);
        step("R3", 1'b0, 1'b0, 0, 32'h0, 32'h0000_0002);
        step("R6", 1'b1, 1'b1, 3, 32'h0000_0002, 32'h0000_0002);
        step("R6", 1'b0, 1'b1, 3, 32'h0, 32'h0000_0002);

        // R7 write to status address ignored
        step("R4", 1'b1, 1'b0, 4, 32'h0F0F_0F0F, 32'hFFFF_FFFF);
        step("R7", 1'b1, 1'b0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        sweep("R7", 32'hFFFF_FFFF);

        // R8 lock bit stored, no side effect
        step("R8", 1'b1, 1'b0, 8, 32'hFFFF_FFFF, 32'h5555_AAAA);
        step("R8", 1'b0, 1'b1, 8, 32'h0, 32'h5555_AAAA);
        step("R8", 1'b1, 1'b0, 8, 32'hFFFF_FFFE, 32'h5555_AAAA);
        step("R8", 1'b0, 1'b1, 8, 32'h0, 32'h5555_AAAA);

        // R9 identification words
        for (int i = 0; i < 8; i++) step("R9", 1'b0, 1'b1, 1016 + i, 32'h0, 32'h0);

        // R11 undefined addresses
        for (int a = 9; a < 16; a++) step("R11", 1'b1, 1'b0, a, 32'hFFFF_FFFF, 32'h0F0F_0000);
        step("R11", 1'b1, 1'b0, 200, 32'hFFFF_FFFF, 32'h0F0F_0000);
        step("R11", 1'b0, 1'b1, 200, 32'h0, 32'h0F0F_0000);
        step("R11", 1'b0, 1'b1, 5, 32'h0, 32'h0F0F_0000);
        step("R11", 1'b0, 1'b1, 7, 32'h0, 32'h0F0F_0000);
        step("R11", 1'b0, 1'b1, 1015, 32'h0, 32'h0F0F_0000);
        sweep("R11", 32'h0F0F_0000);

        // R12 read holds without strobe, read-before-write on collision
        step("R12", 1'b0, 1'b1, 1023, 32'h0, 32'h0);
        step("R12", 1'b0, 1'b0, 4, 32'h0, 32'h0);
        step("R12", 1'b1, 1'b1, 4, 32'hFFFF_FFFF, 32'h0);
        step("R12", 1'b0, 1'b1, 4, 32'h0, 32'h0);

        // mixed traffic
        for (int k = 0; k < 64; k++) begin
            logic [31:0] pat;
            pat = 32'h9E37_79B9 * (k + 1);
            step("R2", 1'b1, 1'b0, 3 + (k % 6), pat ^ (pat >> 7), pat);
            step("R2", 1'b0, 1'b1, k % 9, 32'h0, pat >> 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule